// File: doc/BRIEF.md
# Load-Use and Branch Hazard Controller

This block decides, every cycle, whether a five-stage in-order pipeline advances, freezes its front end, or throws away a fetched instruction. It watches two stages. In the execute stage it looks for a load whose result is not yet available. In the decode stage it looks at the instruction's two source registers and at a branch whose condition has already been compared there. From these it drives the program-counter write enable, the write enable of the fetch/decode register, a bubble request into the decode/execute register, a flush of the fetch/decode register, and a next-PC select with the computed branch target.

Fetch always proceeds down the sequential path. A taken branch therefore wastes only the single instruction fetched behind it. A not-taken branch costs nothing. A load followed at once by a consumer of its result costs one bubble, and forwarding from the memory stage covers the rest. When both events meet, the stall is served first. The branch waits in decode until its operand arrives, and then redirects.

Top module: `hzd_ctrl`

## Requirements
- R1: From reset until the first rising clock edge at which rst_n is sampled high, the outputs are frozen: pc_we=0, ifid_we=0, idex_bubble=1, ifid_flush=1, pc_sel=0.
- R2: When ex_is_load=1 and ex_dst is nonzero and equal to id_src_a or id_src_b, the outputs are pc_we=0, ifid_we=0 and idex_bubble=1.
- R3: A load whose ex_dst is register 0 never causes a stall, even when a decode source is also register 0.
- R4: Without a load-use match, pc_we=1, ifid_we=1 and idex_bubble=0. A load followed by an unrelated instruction loses no cycle.
- R5: A branch in decode (id_is_branch=1, cmp_taken=1) with no stall gives pc_sel=1, ifid_flush=1 and pc_we=1. Exactly one fetched instruction is discarded, and the target enters execute two cycles after the branch does.
- R6: pc_target equals id_pc + 4 + (sign-extended id_offset × 4), modulo 2^PC_W. A branch at 40 with offset 7 goes to 72, and negative offsets go backwards.
- R7: A branch with cmp_taken=0 gives pc_sel=0 and ifid_flush=0 and adds no cycle.
- R8: When a stall and a taken branch coincide, the stall wins: no flush and pc_sel=0. The branch redirects in the following cycle.
- R9: In a pipeline that inserts the requested bubble, a load-use stall lasts exactly one cycle. The consumer enters execute two cycles after the load does.
- R10: cmp_taken has no effect when id_is_branch=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_src_a | input | REG_AW | First source register of the decode instruction |
| id_src_b | input | REG_AW | Second source register of the decode instruction |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| cmp_taken | input | 1 | Result of the decode-stage branch compare |
| id_pc | input | PC_W | Byte address of the decode instruction |
| id_offset | input | OFF_W | Signed word offset of the branch |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_dst | input | REG_AW | Destination register of the execute instruction |
| pc_we | output | 1 | Program counter may update |
| ifid_we | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Load a no-op into decode/execute |
| ifid_flush | output | 1 | Clear fetch/decode to the all-zero no-op |
| pc_sel | output | 1 | Next PC comes from pc_target |
| pc_target | output | PC_W | Branch target address |

## Verification
A wrong decision inside the controller becomes visible at the ports in the same cycle, because every output is a combinational function of the stage inputs and the single reset flop. A stall missed or taken needlessly, a flush on the wrong cycle, or a bad target also shifts the order and timing of the instructions that the pipeline model pushes into execute. A fault that slips past one cycle's output comparison therefore still appears as a wrong instruction index or a wrong arrival cycle, within two cycles of the event.

// File: rtl/hzd_pkg.sv
// Shared types for the hazard controller: the bundle of pipeline control
// outputs and its two fixed settings (frozen and free-running).
package hzd_pkg;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
        logic flush;
        logic pc_sel;
    } hzd_ctl_t;

    localparam hzd_ctl_t CTL_FROZEN = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1,
                                        flush: 1'b1, pc_sel: 1'b0};
    localparam hzd_ctl_t CTL_RUN    = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0,
                                        flush: 1'b0, pc_sel: 1'b0};

endpackage

// File: rtl/hzd_load_use.sv
// Load-use detector: flags when the load in execute writes a register that
// the decode instruction reads. Assumes register 0 is hard-wired to zero,
// so it is never a real dependency. N_SRC source fields are packed LSB-first.
module hzd_load_use #(
    parameter int REG_AW = 5,
    parameter int N_SRC  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ex_is_load,
    input  logic [REG_AW-1:0]       ex_dst,
    input  logic [N_SRC*REG_AW-1:0] id_srcs,
    output logic                    hazard
);

    logic [N_SRC-1:0] src_hit;
    logic             dst_live;

    // Per-source comparison against the load destination.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_hit[g] = (id_srcs[g*REG_AW +: REG_AW] == ex_dst);
    end

    // A load only matters when it writes a real register.
    assign dst_live = ex_is_load && (ex_dst != '0);
    assign hazard   = dst_live && (|src_hit);

    AST_ZERO_DEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !hazard); // R3

endmodule

// File: rtl/hzd_branch.sv
// Decode-stage branch unit: raises a redirect for a taken branch and forms
// the target from the branch address, the next word and the scaled offset.
// Assumes PC_W > OFF_W + 2 and byte addresses of word-aligned instructions.
module hzd_branch #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_is_branch,
    input  logic             cmp_taken,
    input  logic [PC_W-1:0]  id_pc,
    input  logic [OFF_W-1:0] id_offset,
    output logic             redirect,
    output logic [PC_W-1:0]  target
);

    localparam int WORD_SH = 2;
    localparam int EXT_W   = PC_W - OFF_W - WORD_SH;

    logic [PC_W-1:0] off_bytes;

    // Sign-extend the word offset and scale it to bytes.
    assign off_bytes = {{EXT_W{id_offset[OFF_W-1]}}, id_offset, {WORD_SH{1'b0}}};

    // Target is relative to the instruction after the branch.
    assign target   = id_pc + PC_W'(4) + off_bytes;
    assign redirect = id_is_branch && cmp_taken;

    AST_TARGET_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        id_is_branch |-> (target[WORD_SH-1:0] == id_pc[WORD_SH-1:0])); // R6

    AST_NONBRANCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !id_is_branch |-> !redirect); // R10

endmodule

// File: rtl/hzd_seq.sv
// Control sequencer: merges the stall and redirect requests into the pipeline
// control bundle. The stall outranks the redirect. A reset flop keeps the
// front end frozen and cleared until the first edge with reset released.
module hzd_seq
    import hzd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hazard,
    input  logic     redirect,
    output hzd_ctl_t ctl
);

    logic run_q;

    // Synchronous reset flop: becomes 1 on the first edge with rst_n high.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // Priority: frozen, then load-use stall, then branch redirect.
    always_comb begin
        ctl = CTL_RUN;
        if (!run_q) begin
            ctl = CTL_FROZEN;
        end else if (hazard) begin
            ctl.pc_we   = 1'b0;
            ctl.ifid_we = 1'b0;
            ctl.bubble  = 1'b1;
        end else if (redirect) begin
            ctl.flush  = 1'b1;
            ctl.pc_sel = 1'b1;
        end
    end

    AST_FROZEN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctl.bubble && ctl.flush && !ctl.pc_we && !ctl.ifid_we)); // R1

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && hazard) |-> (!ctl.pc_we && !ctl.ifid_we && ctl.bubble)); // R2

    AST_STALL_BEATS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard && redirect) |-> (!ctl.flush && !ctl.pc_sel)); // R8

    AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && hazard) |=> !hazard); // R9

endmodule

// File: rtl/hzd_ctrl.sv
// Top of the hazard controller. Connects the load-use detector, the branch
// unit and the control sequencer. Assumes the pipeline honours each output
// in the cycle it is presented, with the flush taking precedence over ifid_we.
module hzd_ctrl
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int PC_W   = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              id_is_branch,
    input  logic              cmp_taken,
    input  logic [PC_W-1:0]   id_pc,
    input  logic [OFF_W-1:0]  id_offset,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dst,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble,
    output logic              ifid_flush,
    output logic              pc_sel,
    output logic [PC_W-1:0]   pc_target
);

    localparam int N_SRC = 2;

    logic     hazard;
    logic     redirect;
    hzd_ctl_t ctl;

    // Load-use detection over both decode sources.
    hzd_load_use #(.REG_AW(REG_AW), .N_SRC(N_SRC)) u_load_use (
        .clk        (clk),
        .rst_n      (rst_n),
        .ex_is_load (ex_is_load),
        .ex_dst     (ex_dst),
        .id_srcs    ({id_src_b, id_src_a}),
        .hazard     (hazard)
    );

    // Branch decision and target address.
    hzd_branch #(.PC_W(PC_W), .OFF_W(OFF_W)) u_branch (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_is_branch (id_is_branch),
        .cmp_taken    (cmp_taken),
        .id_pc        (id_pc),
        .id_offset    (id_offset),
        .redirect     (redirect),
        .target       (pc_target)
    );

    // Priority merge into the control bundle.
    hzd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hazard   (hazard),
        .redirect (redirect),
        .ctl      (ctl)
    );

    assign pc_we       = ctl.pc_we;
    assign ifid_we     = ctl.ifid_we;
    assign idex_bubble = ctl.bubble;
    assign ifid_flush  = ctl.flush;
    assign pc_sel      = ctl.pc_sel;

    AST_FLUSH_MEANS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_flush && pc_we) |-> (pc_sel && ifid_we && !idex_bubble)); // R5

    AST_NOT_TAKEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !cmp_taken) |-> (!ifid_flush && !pc_sel)); // R7

endmodule

// File: tb/test_hzd_ctrl.sv
// Bench: a small pipeline model drives the controller from its fetch/decode
// and decode/execute slots. A driver queues which instruction must enter
// execute in which cycle. A monitor checks the outputs each cycle and pops
// the queue as instructions arrive in execute.
module test_hzd_ctrl;

    localparam int AW = 5;
    localparam int PW = 32;
    localparam int OW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        bit ok; bit ld; bit br; bit tk;
        int dst; int sa; int sb; int off; int idx; int pc;
    } ins_t;
    typedef struct { int idx; int cyc; } exp_t;

    ins_t  prog [16];
    int    plen, base;
    exp_t  sb_q [$];
    ins_t  id_r, ex_r;
    int    pc_r, cyc;
    bit    run_ref;
    int    checks, errs;
    bit    done;
    string cur_tag;

    logic [AW-1:0] id_src_a, id_src_b, ex_dst;
    logic          id_is_branch, cmp_taken, ex_is_load;
    logic [PW-1:0] id_pc, pc_target;
    logic [OW-1:0] id_offset;
    logic          pc_we, ifid_we, idex_bubble, ifid_flush, pc_sel;

    assign id_src_a     = id_r.sa[AW-1:0];
    assign id_src_b     = id_r.sb[AW-1:0];
    assign id_is_branch = id_r.br;
    assign cmp_taken    = id_r.tk;
    assign id_pc        = id_r.pc;
    assign id_offset    = id_r.off[OW-1:0];
    assign ex_is_load   = ex_r.ld;
    assign ex_dst       = ex_r.dst[AW-1:0];

    hzd_ctrl #(.REG_AW(AW), .PC_W(PW), .OFF_W(OW)) i_hzd_ctrl (
        .clk(clk), .rst_n(rst_n), .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_is_branch(id_is_branch), .cmp_taken(cmp_taken), .id_pc(id_pc),
        .id_offset(id_offset), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .pc_sel(pc_sel), .pc_target(pc_target)
    );

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic ins_t nop_i();
        ins_t n = '{default: 0};
        return n;
    endfunction

    function automatic ins_t mk(bit ld, bit br, bit tk, int dst, int sa, int sb, int off);
        ins_t n = '{default: 0};
        n.ok = 1; n.ld = ld; n.br = br; n.tk = tk;
        n.dst = dst; n.sa = sa; n.sb = sb; n.off = off;
        return n;
    endfunction

    function automatic ins_t fetch(int p);
        int k;
        ins_t n;
        k = (p - base) / 4;
        if (p < base || k >= plen || ((p - base) % 4) != 0) return nop_i();
        n = prog[k];
        n.idx = k;
        n.pc  = p;
        return n;
    endfunction

    // Bench's own view of the reset release edge.
    always @(posedge clk) run_ref <= rst_n;

    // Monitor: per-cycle output checks, pipeline model update, scoreboard pop.
    always @(negedge clk) begin : p_mon
        bit hz, tk;
        ins_t nx_ex, nx_id;
        int nx_pc;
        logic [PW-1:0] tgt;
        exp_t e;
        string rq, brq;
        if (!run_ref) begin
            check_eq("R1", "pc_we", pc_we, 0);
            check_eq("R1", "idex_bubble", idex_bubble, 1);
            check_eq("R1", "ifid_flush", ifid_flush, 1);
            id_r = nop_i(); ex_r = nop_i(); pc_r = base; cyc = 0;
        end else begin
            cyc++;
            hz = ex_r.ld && ex_r.dst != 0 && (ex_r.dst == id_r.sa || ex_r.dst == id_r.sb);
            tk = id_r.br && id_r.tk && !hz;
            rq = hz ? "R2" : (ex_r.ld ? "R3 R4" : "R4");
            check_eq(rq, "pc_we", pc_we, !hz);
            check_eq(rq, "ifid_we", ifid_we, !hz);
            check_eq(rq, "idex_bubble", idex_bubble, hz);
            brq = (id_r.br && id_r.tk && hz) ? "R8" :
                  id_r.br ? (id_r.tk ? "R5" : "R7") : (id_r.tk ? "R10" : "R7");
            check_eq(brq, "ifid_flush", ifid_flush, tk);
            check_eq(brq, "pc_sel", pc_sel, tk);
            if (tk) begin
                tgt = PW'(id_r.pc + 4 + id_r.off * 4);
                check_eq("R6", "pc_target", pc_target, tgt);
            end
            nx_ex = idex_bubble ? nop_i() : id_r;
            nx_id = ifid_flush ? nop_i() : (ifid_we ? fetch(pc_r) : id_r);
            nx_pc = pc_we ? (pc_sel ? int'(pc_target) : pc_r + 4) : pc_r;
            if (ifid_flush && id_r.ok) prog[id_r.idx].tk = 0;   // branch taken once
            ex_r = nx_ex; id_r = nx_id; pc_r = nx_pc;
            if (ex_r.ok) begin
                if (sb_q.size() == 0) begin
                    check_eq(cur_tag, "unexpected EX index", ex_r.idx, -1);
                end else begin
                    e = sb_q.pop_front();
                    check_eq(cur_tag, "EX index", ex_r.idx, e.idx);
                    check_eq(cur_tag, "EX cycle", cyc, e.cyc);
                end
            end
        end
    end

    // Driver helpers.
    task automatic start_prog(int b);
        @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); #2;
        sb_q.delete(); base = b; plen = 0;
    endtask

    task automatic add(ins_t n);
        prog[plen] = n; plen++;
    endtask

    task automatic expect_ex(int idx, int c);
        exp_t e;
        e.idx = idx; e.cyc = c;
        sb_q.push_back(e);
    endtask

    task automatic go(int ncyc, string tag);
        cur_tag = tag;
        @(negedge clk); #2 rst_n = 1'b1;
        repeat (ncyc) @(negedge clk);
        #2 check_eq(tag, "pending EX items", sb_q.size(), 0);
    endtask

    initial begin : p_main
        checks = 0; errs = 0; done = 0; base = 0; plen = 0;
        id_r = nop_i(); ex_r = nop_i(); pc_r = 0; cyc = 0;
        repeat (3) @(negedge clk);

        // Load-use via source b, then a reader two slots away: R2 R9
        start_prog(0);
        add(mk(1, 0, 0, 5, 1, 0, 0));
        add(mk(0, 0, 0, 6, 1, 5, 0));
        add(mk(0, 0, 0, 7, 5, 2, 0));
        expect_ex(0, 2); expect_ex(1, 4); expect_ex(2, 5);
        go(10, "R2 R9 load-use");

        // Load then unrelated, and a load to register 0: R4 R3
        start_prog(0);
        add(mk(1, 0, 0, 5, 1, 0, 0));
        add(mk(0, 0, 0, 8, 6, 7, 0));
        add(mk(0, 0, 0, 9, 5, 2, 0));
        add(mk(1, 0, 0, 0, 1, 0, 0));
        add(mk(0, 0, 0, 4, 0, 0, 0));
        expect_ex(0, 2); expect_ex(1, 3); expect_ex(2, 4); expect_ex(3, 5); expect_ex(4, 6);
        go(10, "R3 R4 no stall");

        // Taken branch forward by two words: R5
        start_prog(0);
        add(mk(0, 0, 0, 1, 2, 3, 0));
        add(mk(0, 1, 1, 0, 1, 2, 2));
        add(mk(0, 0, 0, 2, 3, 4, 0));
        add(mk(0, 0, 0, 3, 4, 5, 0));
        add(mk(0, 0, 0, 4, 5, 6, 0));
        add(mk(0, 0, 0, 5, 6, 7, 0));
        expect_ex(0, 2); expect_ex(1, 3); expect_ex(4, 5); expect_ex(5, 6);
        go(10, "R5 taken");

        // Not-taken branch, then a non-branch with cmp_taken high: R7 R10
        start_prog(0);
        add(mk(0, 1, 0, 0, 1, 2, 3));
        add(mk(0, 0, 1, 3, 1, 2, 5));
        add(mk(0, 0, 0, 4, 1, 2, 0));
        expect_ex(0, 2); expect_ex(1, 3); expect_ex(2, 4);
        go(9, "R7 R10 not taken");

        // Branch at address 40 with offset 7 lands on 72: R6
        start_prog(36);
        add(mk(0, 0, 0, 10, 4, 8, 0));
        add(mk(0, 1, 1, 0, 1, 3, 7));
        for (int k = 2; k < 9; k++) add(mk(0, 0, 0, k, 2, 5, 0));
        add(mk(1, 0, 0, 4, 7, 0, 0));
        expect_ex(0, 2); expect_ex(1, 3); expect_ex(9, 5);
        go(9, "R6 target 72");

        // Stall and taken branch together: R8
        start_prog(0);
        add(mk(1, 0, 0, 3, 1, 0, 0));
        add(mk(0, 1, 1, 0, 3, 4, 1));
        add(mk(0, 0, 0, 5, 1, 2, 0));
        add(mk(0, 0, 0, 6, 1, 2, 0));
        expect_ex(0, 2); expect_ex(1, 4); expect_ex(3, 6);
        go(10, "R8 stall over branch");

        // Backward branch with negative offset, taken once: R6 R5
        start_prog(0);
        add(mk(0, 0, 0, 1, 2, 3, 0));
        add(mk(0, 0, 0, 2, 3, 4, 0));
        add(mk(0, 1, 1, 0, 1, 2, -2));
        add(mk(0, 0, 0, 3, 4, 5, 0));
        expect_ex(0, 2); expect_ex(1, 3); expect_ex(2, 4);
        expect_ex(1, 6); expect_ex(2, 7); expect_ex(3, 8);
        go(12, "R6 R5 backward");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : p_watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule